// File: doc/BRIEF.md
# MSI-X Interrupt Message Engine

This block turns per-vector interrupt requests from a device function into memory write requests that carry an interrupt message. It keeps a small vector table, a pending-bit array and the message control bits of the MSI-X capability. A request on a vector that is allowed to fire becomes a single write of that vector's 32-bit data word to its 64-bit address. The write is offered on a valid/ready handshake.

A request that arrives while its vector is masked, or while the whole function is masked, only sets the vector's pending bit. Once the mask is lifted, the block sends the message and clears the bit. Software reaches the table, the pending bits and the capability header through a simple register port that accepts 32-bit or 64-bit stores, with reads returned combinationally.

The block holds one message in flight at a time. When several vectors are waiting, it serves the lowest-numbered one first. The enable bit gates everything. Plain MSI, signalled by an input, takes precedence over the enable bit.

Top module: `msgx_engine`

## Requirements
- R1: The capability dword, at region 2'b10 (register address bits [AW-1:AW-2]) with index 0, reads as follows: bits 7:0 = 0x11, bits 15:8 = 0, bits 26:16 = NUM_VEC-1, bits 29:27 = 0, bit 30 = function mask, bit 31 = enable. A 32-bit store there updates only bits 31 and 30.
- R2: After reset, the following hold: enable = 0, function mask = 0, every vector mask = 1, every address and data field = 0, every pending bit = 0, and no message is offered.
- R3: The table is region 2'b00, and dword index 4*v+k addresses vector v. k=0 is the lower address, with bits 1:0 always reading 0. k=1 is the upper address. k=2 is the data word. k=3 is vector control, where bit 0 is the mask and every other bit reads 0.
- R4: A 64-bit store to k=0 writes the lower address from wdata[31:0] and the upper address from wdata[63:32]. The result is identical to two 32-bit stores.
- R5: With the block enabled and vector v unmasked, a request on v offers one message with address {upper,lower} and data equal to v's data word. The message holds stable while msg_valid is high and msg_ready is low.
- R6: A request on a vector whose own mask or the function mask is set produces no message. It sets that vector's pending bit, which is bit v of PBA dword 0 (region 2'b01).
- R7: When the last mask over a pending vector is cleared while enabled, that vector's message is sent and its pending bit returns to 0.
- R8: When several vectors are pending and eligible, messages leave in ascending vector order, and a new message is never offered while one is outstanding.
- R9: While the enable bit is 0, requests are dropped: no pending bit is set and no message is sent.
- R10: While msi_active is high, the block behaves as if disabled, and the stored enable bit still reads back unchanged.
- R11: Address and data of an offered message are captured when it is launched, so table writes made while it waits leave msg_addr and msg_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_VEC | Per-vector interrupt request, one event per cycle high |
| msi_active | input | 1 | Plain MSI is enabled elsewhere; suppresses this block |
| reg_we | input | 1 | Register store strobe |
| reg_wide | input | 1 | Store is 64 bits wide (else 32) |
| reg_addr | input | AW | Dword register address: region in top two bits, index below |
| reg_wdata | input | 64 | Store data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The bench programs every vector with a distinct address and data word, alternating 64-bit and split 32-bit stores so that the two store paths are compared. It first fires each vector alone while unmasked, which ties each message to the right table entry. It then fires vectors under a per-vector mask, under the function mask, with the block disabled and with plain MSI active. These cases separate latching from dropping and show that replay happens on unmask. A simultaneous burst on scattered vectors checks ascending service order, and a table write during a stalled handshake shows that the message was captured at launch.

// File: rtl/msgx_pkg.sv
package msgx_pkg;

    localparam logic [7:0] CAP_ID = 8'h11;

    typedef enum logic [1:0] {
        RGN_TABLE = 2'b00,
        RGN_PBA   = 2'b01,
        RGN_CAP   = 2'b10,
        RGN_NONE  = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        FLD_ADDR_LO = 2'd0,
        FLD_ADDR_HI = 2'd1,
        FLD_DATA    = 2'd2,
        FLD_CTRL    = 2'd3
    } field_e;

    typedef struct packed {
        logic [63:0] addr;
        logic [31:0] data;
    } msg_t;

    typedef struct packed {
        logic [31:0] addr_lo;
        logic [31:0] addr_hi;
        logic [31:0] data;
        logic        masked;
    } entry_t;

    typedef enum logic {
        DSP_IDLE = 1'b0,
        DSP_BUSY = 1'b1
    } dsp_state_e;

    function automatic logic [31:0] cap_word(logic en, logic fm, logic [10:0] size_m1);
        return {en, fm, 3'b000, size_m1, 8'h00, CAP_ID};
    endfunction

endpackage

// File: rtl/msgx_vec_table.sv
module msgx_vec_table
    import msgx_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VW     = $clog2(NUM_VEC),
    localparam int IDX_W  = VW + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_wide,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [63:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic [NUM_VEC-1:0] vmask,
    input  logic [VW-1:0]    pick_idx,
    output msg_t             pick_msg
);

    entry_t ents [NUM_VEC];

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
        logic hit;
        assign hit = wr_en && (wr_idx[IDX_W-1:2] == VW'(v));

        always_ff @(posedge clk) begin
            if (rst) begin
                ents[v].addr_lo <= '0;
                ents[v].addr_hi <= '0;
                ents[v].data    <= '0;
                ents[v].masked  <= 1'b1;
            end else if (hit) begin
                case (field_e'(wr_idx[1:0]))
                    FLD_ADDR_LO: begin
                        ents[v].addr_lo <= {wr_data[31:2], 2'b00};
                        if (wr_wide) ents[v].addr_hi <= wr_data[63:32];
                    end
                    FLD_ADDR_HI: ents[v].addr_hi <= wr_data[31:0];
                    FLD_DATA: begin
                        ents[v].data <= wr_data[31:0];
                        if (wr_wide) ents[v].masked <= wr_data[32];
                    end
                    FLD_CTRL: ents[v].masked <= wr_data[0];
                    default: ;
                endcase
            end
        end

        assign vmask[v] = ents[v].masked;
    end

    logic [VW-1:0] rd_vec;
    assign rd_vec = rd_idx[IDX_W-1:2];

    always_comb begin
        rd_data = '0;
        if (int'(rd_vec) < NUM_VEC) begin
            case (field_e'(rd_idx[1:0]))
                FLD_ADDR_LO: rd_data = ents[rd_vec].addr_lo;
                FLD_ADDR_HI: rd_data = ents[rd_vec].addr_hi;
                FLD_DATA:    rd_data = ents[rd_vec].data;
                FLD_CTRL:    rd_data = {31'b0, ents[rd_vec].masked};
                default:     rd_data = '0;
            endcase
        end
    end

    always_comb begin
        pick_msg.addr = {ents[pick_idx].addr_hi, ents[pick_idx].addr_lo};
        pick_msg.data = ents[pick_idx].data;
    end

endmodule

// File: rtl/msgx_pending.sv
module msgx_pending #(
    parameter int NUM_VEC = 8,
    localparam int VW     = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] set_req,
    input  logic               clr_en,
    input  logic [VW-1:0]      clr_idx,
    input  logic [NUM_VEC-1:0] allow,
    output logic [NUM_VEC-1:0] pend,
    output logic               found,
    output logic [VW-1:0]      pick_idx
);

    logic [NUM_VEC-1:0] clr_vec;
    assign clr_vec = clr_en ? (NUM_VEC'(1) << clr_idx) : '0;

    // a new request in the same cycle as a launch of that vector wins
    always_ff @(posedge clk) begin
        if (rst) pend <= '0;
        else     pend <= (pend & ~clr_vec) | set_req;
    end

    // lowest eligible index: scan downward so the last hit is the smallest
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int i = NUM_VEC - 1; i >= 0; i--) begin
            if (pend[i] && allow[i]) begin
                found    = 1'b1;
                pick_idx = VW'(i);
            end
        end
    end

endmodule

// File: rtl/msgx_dispatch.sv
module msgx_dispatch
    import msgx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  msg_t in_msg,
    input  logic out_ready,
    output logic out_valid,
    output msg_t out_msg,
    output logic launch
);

    dsp_state_e state;

    assign launch    = (state == DSP_IDLE) && go;
    assign out_valid = (state == DSP_BUSY);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= DSP_IDLE;
            out_msg <= '0;
        end else begin
            case (state)
                DSP_IDLE: if (go) begin
                    state   <= DSP_BUSY;
                    out_msg <= in_msg;
                end
                DSP_BUSY: if (out_ready) state <= DSP_IDLE;
                default: state <= DSP_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/msgx_engine.sv
module msgx_engine
    import msgx_pkg::*;
#(
    parameter int NUM_VEC = 8,
    localparam int VW        = $clog2(NUM_VEC),
    localparam int IDX_W     = VW + 2,
    localparam int AW        = IDX_W + 2,
    localparam int PBA_WORDS = (NUM_VEC + 31) / 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] irq_req,
    input  logic               msi_active,
    input  logic               reg_we,
    input  logic               reg_wide,
    input  logic [AW-1:0]      reg_addr,
    input  logic [63:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [63:0]        msg_addr,
    output logic [31:0]        msg_data
);

    region_e          region;
    logic [IDX_W-1:0] index;
    assign region = region_e'(reg_addr[AW-1:AW-2]);
    assign index  = reg_addr[IDX_W-1:0];

    // message control bits
    logic en_q, fmask;
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            fmask <= 1'b0;
        end else if (reg_we && region == RGN_CAP && index == '0) begin
            en_q  <= reg_wdata[31];
            fmask <= reg_wdata[30];
        end
    end

    logic live_en;
    assign live_en = en_q && !msi_active;

    logic [31:0]        tbl_rdata;
    logic [NUM_VEC-1:0] vmask;
    logic [VW-1:0]      pick_idx;
    msg_t               pick_msg;

    msgx_vec_table #(.NUM_VEC(NUM_VEC)) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_we && region == RGN_TABLE),
        .wr_wide  (reg_wide),
        .wr_idx   (index),
        .wr_data  (reg_wdata),
        .rd_idx   (index),
        .rd_data  (tbl_rdata),
        .vmask    (vmask),
        .pick_idx (pick_idx),
        .pick_msg (pick_msg)
    );

    logic [NUM_VEC-1:0] pend;
    logic [NUM_VEC-1:0] allow;
    logic               found;
    logic               launch;

    assign allow = ~vmask & {NUM_VEC{~fmask}};

    msgx_pending #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .set_req  (irq_req & {NUM_VEC{live_en}}),
        .clr_en   (launch),
        .clr_idx  (pick_idx),
        .allow    (allow),
        .pend     (pend),
        .found    (found),
        .pick_idx (pick_idx)
    );

    msg_t out_msg;

    msgx_dispatch u_dsp (
        .clk       (clk),
        .rst       (rst),
        .go        (found && live_en),
        .in_msg    (pick_msg),
        .out_ready (msg_ready),
        .out_valid (msg_valid),
        .out_msg   (out_msg),
        .launch    (launch)
    );

    assign msg_addr = out_msg.addr;
    assign msg_data = out_msg.data;

    logic [PBA_WORDS*32-1:0] pba_flat;
    assign pba_flat = {{(PBA_WORDS*32-NUM_VEC){1'b0}}, pend};

    always_comb begin
        reg_rdata = '0;
        case (region)
            RGN_TABLE: reg_rdata = tbl_rdata;
            RGN_PBA:   if (int'(index) < PBA_WORDS) reg_rdata = pba_flat[int'(index)*32 +: 32];
            RGN_CAP:   if (index == '0) reg_rdata = cap_word(en_q, fmask, 11'(NUM_VEC - 1));
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/msgx_engine_chk.sv
module msgx_engine_chk #(
    parameter int NUM_VEC = 8,
    localparam int VW     = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst,
    input logic               msg_valid,
    input logic               msg_ready,
    input logic [63:0]        msg_addr,
    input logic [31:0]        msg_data,
    input logic               live_en,
    input logic [NUM_VEC-1:0] pend,
    input logic               launch,
    input logic               fmask,
    input logic [NUM_VEC-1:0] vmask,
    input logic [VW-1:0]      pick_idx
);

    // R5
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data));

    // R9
    no_gain_off_chk: assert property (@(posedge clk) disable iff (rst)
        !live_en |=> (pend & ~$past(pend)) == '0);

    // R10
    quiet_off_chk: assert property (@(posedge clk) disable iff (rst)
        !live_en && !msg_valid |=> !msg_valid);

    // R6
    launch_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> !fmask && !vmask[pick_idx]);

    // R8
    single_out_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> !msg_valid);

endmodule

bind msgx_engine msgx_engine_chk #(.NUM_VEC(NUM_VEC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .msg_valid (msg_valid),
    .msg_ready (msg_ready),
    .msg_addr  (msg_addr),
    .msg_data  (msg_data),
    .live_en   (live_en),
    .pend      (pend),
    .launch    (launch),
    .fmask     (fmask),
    .vmask     (vmask),
    .pick_idx  (pick_idx)
);

// File: tb/msgx_engine_bench.sv
module msgx_engine_bench;

    localparam int N  = 8;
    localparam int AW = 7;
    localparam logic [AW-1:0] PBA_A = 7'h20;
    localparam logic [AW-1:0] CAP_A = 7'h40;

    logic          clk = 0;
    logic          rst = 1;
    logic [N-1:0]  irq_req = '0;
    logic          msi_active = 0;
    logic          reg_we = 0;
    logic          reg_wide = 0;
    logic [AW-1:0] reg_addr = '0;
    logic [63:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          msg_valid;
    logic          msg_ready = 0;
    logic [63:0]   msg_addr;
    logic [31:0]   msg_data;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    msgx_engine #(.NUM_VEC(N)) u_msgx_engine (
        .clk(clk), .rst(rst), .irq_req(irq_req), .msi_active(msi_active),
        .reg_we(reg_we), .reg_wide(reg_wide), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual cycles %0d expected below 100000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [AW-1:0] tbl(int v, int k);
        return AW'(v * 4 + k);
    endfunction
    function automatic logic [31:0] exp_lo(int v);  return 32'h1000_0000 + 32'(v) * 32'h40; endfunction
    function automatic logic [31:0] exp_hi(int v);  return 32'h0000_0F00 + 32'(v); endfunction
    function automatic logic [31:0] exp_dat(int v); return 32'h5000_0000 | (32'(v) * 32'h11); endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [63:0] d, logic wide);
        @(negedge clk);
        reg_we = 1; reg_wide = wide; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0; reg_wide = 0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic fire(logic [N-1:0] m);
        @(negedge clk);
        irq_req = m;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic wait_msg(output bit got);
        got = 0;
        for (int i = 0; i < 20 && !got; i++) begin
            @(negedge clk);
            if (msg_valid) got = 1;
        end
    endtask

    task automatic quiet(string tag, int n);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (msg_valid) seen++;
        end
        chk(tag, 64'(seen), 64'd0);
    endtask

    task automatic take_msg(string tag, int v);
        bit got;
        wait_msg(got);
        chk({tag, " valid"}, 64'(got), 64'd1);
        chk({tag, " addr"}, msg_addr, {exp_hi(v), exp_lo(v)});
        chk({tag, " data"}, 64'(msg_data), 64'(exp_dat(v)));
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
    endtask

    initial begin
        logic [31:0] d;
        bit got;

        repeat (3) @(negedge clk);
        rst = 0;

        // R1 R2: reset state
        rd(CAP_A, d);   chk("R1 R2 cap after reset", 64'(d), 64'h0007_0011);
        rd(PBA_A, d);   chk("R2 pba after reset", 64'(d), 64'd0);
        chk("R2 no message after reset", 64'(msg_valid), 64'd0);
        for (int v = 0; v < N; v++) begin
            rd(tbl(v, 3), d); chk("R2 vector masked at reset", 64'(d), 64'd1);
            rd(tbl(v, 0), d); chk("R2 addr zero at reset", 64'(d), 64'd0);
            rd(tbl(v, 2), d); chk("R2 data zero at reset", 64'(d), 64'd0);
        end

        // R3 R4: program table, odd vectors with one wide store
        for (int v = 0; v < N; v++) begin
            if (v % 2 == 0) begin
                wr(tbl(v, 0), 64'(exp_lo(v) | 32'h3), 0);
                wr(tbl(v, 1), 64'(exp_hi(v)), 0);
            end else begin
                wr(tbl(v, 0), {exp_hi(v), exp_lo(v) | 32'h3}, 1);
            end
            wr(tbl(v, 2), 64'(exp_dat(v)), 0);
            wr(tbl(v, 3), 64'hFFFF_FFFE, 0);
        end
        for (int v = 0; v < N; v++) begin
            rd(tbl(v, 0), d); chk("R3 R4 addr lo low bits zero", 64'(d), 64'(exp_lo(v)));
            rd(tbl(v, 1), d); chk("R4 addr hi", 64'(d), 64'(exp_hi(v)));
            rd(tbl(v, 2), d); chk("R3 data", 64'(d), 64'(exp_dat(v)));
            rd(tbl(v, 3), d); chk("R3 ctrl only bit0", 64'(d), 64'd0);
        end

        // R9: disabled, requests dropped
        fire('1);
        quiet("R9 no message while disabled", 6);
        rd(PBA_A, d); chk("R9 no pending while disabled", 64'(d), 64'd0);

        // R1 R5: enable, each vector alone
        wr(CAP_A, 64'h8000_FFFF, 0);
        rd(CAP_A, d); chk("R1 cap after enable", 64'(d), 64'h8007_0011);
        for (int v = 0; v < N; v++) begin
            fire(N'(1) << v);
            wait_msg(got);
            chk("R5 valid", 64'(got), 64'd1);
            chk("R5 addr", msg_addr, {exp_hi(v), exp_lo(v)});
            chk("R5 data", 64'(msg_data), 64'(exp_dat(v)));
            repeat (3) @(negedge clk);
            chk("R5 held while not ready", {31'b0, msg_valid, msg_data}, {32'd1, exp_dat(v)});
            msg_ready = 1;
            @(negedge clk);
            msg_ready = 0;
            chk("R5 released after ready", 64'(msg_valid), 64'd0);
        end
        rd(PBA_A, d); chk("R5 pba empty after sends", 64'(d), 64'd0);

        // R6 R7: per-vector mask then unmask
        wr(tbl(2, 3), 64'd1, 0);
        fire(N'(1) << 2);
        quiet("R6 masked vector silent", 5);
        rd(PBA_A, d); chk("R6 pending bit 2", 64'(d), 64'h4);
        wr(tbl(2, 3), 64'd0, 0);
        take_msg("R7 replay vector 2", 2);
        rd(PBA_A, d); chk("R7 pending cleared", 64'(d), 64'd0);

        // R6 R8: function mask, burst, ascending order
        wr(CAP_A, 64'hC000_0000, 0);
        rd(CAP_A, d); chk("R1 cap with function mask", 64'(d), 64'hC007_0011);
        fire(8'b0110_0010);
        quiet("R6 function mask silent", 5);
        rd(PBA_A, d); chk("R6 pending under function mask", 64'(d), 64'h62);
        wr(CAP_A, 64'h8000_0000, 0);
        begin
            int order[3] = '{1, 5, 6};
            int n = 0;
            msg_ready = 1;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (msg_valid) begin
                    if (n < 3) chk("R8 ascending order", 64'(msg_data), 64'(exp_dat(order[n])));
                    n++;
                end
            end
            msg_ready = 0;
            chk("R8 message count", 64'(n), 64'd3);
        end
        rd(PBA_A, d); chk("R7 pending cleared after burst", 64'(d), 64'd0);

        // R11: capture at launch
        fire(N'(1) << 3);
        wait_msg(got);
        wr(tbl(3, 2), 64'hDEAD_BEEF, 0);
        chk("R11 data captured", 64'(msg_data), 64'(exp_dat(3)));
        chk("R11 still valid", 64'(msg_valid), 64'd1);
        msg_ready = 1;
        @(negedge clk);
        msg_ready = 0;
        wr(tbl(3, 2), 64'(exp_dat(3)), 0);

        // R10: plain MSI suppresses
        msi_active = 1;
        fire(N'(1) << 4);
        quiet("R10 no message with msi_active", 5);
        rd(PBA_A, d); chk("R10 no pending with msi_active", 64'(d), 64'd0);
        rd(CAP_A, d); chk("R10 enable reads back", 64'(d), 64'h8007_0011);
        msi_active = 0;
        fire(N'(1) << 4);
        take_msg("R10 resumes", 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule